// File: doc/BRIEF.md
# CAN Controller Interrupt and Status Unit

This block is the register-mapped control and status core that sits between a CAN protocol engine and the host. It holds the operating-mode register, decodes a write-only command register into one-cycle command pulses, keeps eight interrupt flags with per-source enables, and drives a single interrupt line. It also keeps the receive-buffer-ready and overrun status bits, and it holds the transmit and receive error counters. It captures the details of the most recent bus error and arbitration loss.

The protocol engine reports events as one-cycle pulses on an eight-bit event vector. Bus-error and arbitration-loss pulses carry capture data with them. Level status from the engine (busy, ready, error state, bus off) is registered into the status word. The host sees six 32-bit registers on a simple word-addressed bus. Writes take effect on the clock edge. Reads are combinational from the held state.

The register word addresses are: 0 mode, 1 command, 2 status, 3 interrupt flags, 4 interrupt enables, 5 error counters.

Top module: `can_irq_status_core`

## Requirements
- R1: After synchronous reset, the mode register reads 0x1, status reads 0x3C, and the flag, enable and error-counter registers read 0. The irq output is low.
- R2: A pulse on `evt_i` bit k sets interrupt flag k one edge later, whether or not the flag is enabled. The bit order is: 0 receive valid, 1 transmit done, 2 error warning, 3 overrun, 4 wakeup, 5 error passive, 6 arbitration lost, 7 bus error.
- R3: Writing the flag register (address 3) clears every flag whose data bit is 1 and leaves the others unchanged. If an event for a flag arrives in the same cycle as its clear, the flag stays set.
- R4: `irq_o` is high exactly when some flag is set whose enable bit is also set. The enable register (address 4) uses the same bit positions as the flags.
- R5: Mode register (address 0): bit 0 reset mode, bit 1 listen-only, bit 2 loopback, bit 3 single filter, bit 4 sleep. Bits 0 to 2 are written on every write. Bits 3 and 4 are written only if reset mode was already set before the write. `mode_o` presents the register.
- R6: The command register (address 1) always reads 0. Each 1 written to it appears on `cmd_o` at the same bit for exactly one cycle after the write edge. The command bits are: 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-reception, 5 bus-off request.
- R7: Status bit 0 (receive buffer ready) is set by a receive-valid event and cleared by command bit 2. Status bit 1 (overrun) is set by an overrun event and cleared only by command bit 3; a write to the flag register does not clear it. In both bits a same-cycle set wins over the clear.
- R8: Status bits 7:2 show `eng_lvl_i` registered one edge earlier. Their reset value makes bits 5:2 read 1.
- R9: A bus-error event captures the error type (0 bit, 1 form, 2 stuff, 3 other) into status bits 23:22, the direction (1 receive) into bit 21, and the segment code into bits 20:16. This happens only if flag 7 is clear or is being cleared in that cycle. Otherwise the captured value stays frozen.
- R10: An arbitration-lost event captures `arb_pos_i` into status bits 12:8 under the same freeze rule, using flag 6.
- R11: The error-counter register (address 5) holds the transmit count in bits 7:0 and the receive count in bits 23:16. An engine update loads both counts. A host write loads both fields from the same bit positions, so writing 0 clears them. A host write wins over a same-cycle engine update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_i | input | 8 | Event pulses from the protocol engine, one per interrupt source |
| berr_kind_i | input | 2 | Bus error type, sampled with `evt_i[7]` |
| berr_rx_i | input | 1 | Bus error direction (1 = receiving), sampled with `evt_i[7]` |
| berr_seg_i | input | 5 | Frame segment code of the bus error |
| arb_pos_i | input | 5 | Bit position of arbitration loss, sampled with `evt_i[6]` |
| eng_lvl_i | input | 6 | Level status: tx buffer ready, tx complete, rx busy, tx busy, error status, bus off |
| ecnt_upd_i | input | 1 | Error counter update strobe from the engine |
| ecnt_tx_i | input | 8 | New transmit error count |
| ecnt_rx_i | input | 8 | New receive error count |
| mode_o | output | 5 | Mode register contents |
| cmd_o | output | 6 | One-cycle command pulses |
| irq_o | output | 1 | Interrupt line |

## Verification
Each of the eight sources is raised alone, and the bench checks its flag position and its irq gating both with the source enabled and disabled, so a swapped bit or a missing gate shows up. All 256 clear masks are applied over a full flag set, and all 256 enable masks are applied over a fixed flag pattern. Together these separate write-one-to-clear from plain write and distinguish AND gating from any other combination. All 256 bus-error capture words and all 32 arbitration positions are captured in turn, each followed by a conflicting event that must leave the capture frozen. Mode writes are made with reset mode set and with it clear, and same-cycle set/clear collisions are checked for flags, the overrun bit and the error counters.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;

    localparam int DATA_W  = 32;
    localparam int NSRC    = 8;
    localparam int CMD_W   = 6;
    localparam int LVL_W   = 6;
    localparam int SEG_W   = 5;
    localparam int POS_W   = 5;
    localparam int CNT_W   = 8;

    // word addresses
    localparam int ADR_MODE = 0;
    localparam int ADR_CMD  = 1;
    localparam int ADR_STAT = 2;
    localparam int ADR_FLAG = 3;
    localparam int ADR_EN   = 4;
    localparam int ADR_ECNT = 5;

    // event / flag bit positions
    localparam int SRC_RX   = 0;
    localparam int SRC_OVR  = 3;
    localparam int SRC_ARB  = 6;
    localparam int SRC_BERR = 7;

    // command bit positions
    localparam int CMD_RELEASE = 2;
    localparam int CMD_CLR_OVR = 3;

    localparam logic [LVL_W-1:0] LVL_RST = 6'b00_1111;

    typedef struct packed {
        logic [1:0]       kind;
        logic             rx_dir;
        logic [SEG_W-1:0] seg;
    } berr_cap_t;

    typedef struct packed {
        logic sleep;
        logic single_flt;
        logic loopback;
        logic listen;
        logic rst_mode;
    } mode_t;

    localparam mode_t MODE_RST = '{sleep: 1'b0, single_flt: 1'b0, loopback: 1'b0,
                                   listen: 1'b0, rst_mode: 1'b1};

    function automatic logic [DATA_W-1:0] pack_status(
        input berr_cap_t        b,
        input logic [POS_W-1:0] arb,
        input logic [LVL_W-1:0] lvl,
        input logic             ovr,
        input logic             rx_rdy);
        return {8'h00, b, 3'b000, arb, lvl, ovr, rx_rdy};
    endfunction

endpackage

// File: rtl/can_irq_flags.sv
module can_irq_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)           bit_q <= 1'b0;
            else if (evt_i[i]) bit_q <= 1'b1;
            else if (clr_i[i]) bit_q <= 1'b0;
        end
        assign flag_o[i] = bit_q;

        // R2
        evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
            evt_i[i] |=> bit_q);
        // R3
        w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !evt_i[i]) |=> !bit_q);
    end

    assign irq_o = |(flag_o & en_i);

    // R4
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
    import can_ctl_pkg::*;
#(
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          berr_evt_i,
    input  logic          berr_held_i,
    input  berr_cap_t     berr_i,
    input  logic          arb_evt_i,
    input  logic          arb_held_i,
    input  logic [PW-1:0] arb_pos_i,
    output berr_cap_t     berr_o,
    output logic [PW-1:0] arb_o
);
    berr_cap_t     berr_q;
    logic [PW-1:0] arb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            berr_q <= '0;
            arb_q  <= '0;
        end else begin
            if (berr_evt_i && !berr_held_i) berr_q <= berr_i;
            if (arb_evt_i && !arb_held_i)   arb_q  <= arb_pos_i;
        end
    end

    assign berr_o = berr_q;
    assign arb_o  = arb_q;

    // R9
    berr_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        berr_held_i |=> $stable(berr_q));
    // R10
    arb_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        arb_held_i |=> $stable(arb_q));
endmodule

// File: rtl/can_cfg_regs.sv
module can_cfg_regs
    import can_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode_i,
    input  logic              wr_cmd_i,
    input  logic              wr_en_i,
    input  logic              wr_ecnt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              evt_rx_i,
    input  logic              evt_ovr_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              ecnt_upd_i,
    input  logic [CNT_W-1:0]  ecnt_tx_i,
    input  logic [CNT_W-1:0]  ecnt_rx_i,
    output mode_t             mode_o,
    output logic [NSRC-1:0]   en_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              rx_rdy_o,
    output logic              ovr_o,
    output logic [LVL_W-1:0]  lvl_o,
    output logic [CNT_W-1:0]  tec_o,
    output logic [CNT_W-1:0]  rec_o
);
    mode_t            mode_q;
    logic [NSRC-1:0]  en_q;
    logic [CMD_W-1:0] cmd_q;
    logic             rx_rdy_q, ovr_q;
    logic [LVL_W-1:0] lvl_q;
    logic [CNT_W-1:0] tec_q, rec_q;

    logic do_release, do_clr_ovr;
    assign do_release = wr_cmd_i && wdata_i[CMD_RELEASE];
    assign do_clr_ovr = wr_cmd_i && wdata_i[CMD_CLR_OVR];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_RST;
            en_q     <= '0;
            cmd_q    <= '0;
            rx_rdy_q <= 1'b0;
            ovr_q    <= 1'b0;
            lvl_q    <= LVL_RST;
            tec_q    <= '0;
            rec_q    <= '0;
        end else begin
            if (wr_mode_i) begin
                mode_q.rst_mode <= wdata_i[0];
                mode_q.listen   <= wdata_i[1];
                mode_q.loopback <= wdata_i[2];
                if (mode_q.rst_mode) begin
                    mode_q.single_flt <= wdata_i[3];
                    mode_q.sleep      <= wdata_i[4];
                end
            end
            if (wr_en_i) en_q <= wdata_i[NSRC-1:0];
            cmd_q <= wr_cmd_i ? wdata_i[CMD_W-1:0] : '0;

            if (evt_rx_i)        rx_rdy_q <= 1'b1;
            else if (do_release) rx_rdy_q <= 1'b0;
            if (evt_ovr_i)       ovr_q <= 1'b1;
            else if (do_clr_ovr) ovr_q <= 1'b0;

            lvl_q <= lvl_i;

            if (wr_ecnt_i) begin
                tec_q <= wdata_i[CNT_W-1:0];
                rec_q <= wdata_i[16 +: CNT_W];
            end else if (ecnt_upd_i) begin
                tec_q <= ecnt_tx_i;
                rec_q <= ecnt_rx_i;
            end
        end
    end

    assign mode_o   = mode_q;
    assign en_o     = en_q;
    assign cmd_o    = cmd_q;
    assign rx_rdy_o = rx_rdy_q;
    assign ovr_o    = ovr_q;
    assign lvl_o    = lvl_q;
    assign tec_o    = tec_q;
    assign rec_o    = rec_q;

    // R5
    mode_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mode_i && !mode_q.rst_mode) |=> $stable({mode_q.sleep, mode_q.single_flt}));
    // R6
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_cmd_i |=> (cmd_q == '0));
    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !do_clr_ovr) |=> ovr_q);
    // R11
    ecnt_host_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ecnt_i && wdata_i == '0) |=> (tec_q == '0 && rec_q == '0));
endmodule

// File: rtl/can_irq_status_core.sv
module can_irq_status_core
    import can_ctl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   evt_i,
    input  logic [1:0]        berr_kind_i,
    input  logic              berr_rx_i,
    input  logic [SEG_W-1:0]  berr_seg_i,
    input  logic [POS_W-1:0]  arb_pos_i,
    input  logic [LVL_W-1:0]  eng_lvl_i,
    input  logic              ecnt_upd_i,
    input  logic [CNT_W-1:0]  ecnt_tx_i,
    input  logic [CNT_W-1:0]  ecnt_rx_i,
    output logic [4:0]        mode_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              irq_o
);
    logic sel_mode, sel_cmd, sel_flag, sel_en, sel_ecnt;
    assign sel_mode = reg_we && (reg_addr == ADDR_W'(ADR_MODE));
    assign sel_cmd  = reg_we && (reg_addr == ADDR_W'(ADR_CMD));
    assign sel_flag = reg_we && (reg_addr == ADDR_W'(ADR_FLAG));
    assign sel_en   = reg_we && (reg_addr == ADDR_W'(ADR_EN));
    assign sel_ecnt = reg_we && (reg_addr == ADDR_W'(ADR_ECNT));

    logic [NSRC-1:0] clr, flags, en;
    assign clr = sel_flag ? reg_wdata[NSRC-1:0] : '0;

    mode_t            mode;
    logic             rx_rdy, ovr;
    logic [LVL_W-1:0] lvl;
    logic [CNT_W-1:0] tec, rec;
    berr_cap_t        berr_cap, berr_in;
    logic [POS_W-1:0] arb_cap;

    can_cfg_regs u_cfg (
        .clk(clk), .rst(rst),
        .wr_mode_i(sel_mode), .wr_cmd_i(sel_cmd), .wr_en_i(sel_en), .wr_ecnt_i(sel_ecnt),
        .wdata_i(reg_wdata),
        .evt_rx_i(evt_i[SRC_RX]), .evt_ovr_i(evt_i[SRC_OVR]),
        .lvl_i(eng_lvl_i),
        .ecnt_upd_i(ecnt_upd_i), .ecnt_tx_i(ecnt_tx_i), .ecnt_rx_i(ecnt_rx_i),
        .mode_o(mode), .en_o(en), .cmd_o(cmd_o),
        .rx_rdy_o(rx_rdy), .ovr_o(ovr), .lvl_o(lvl),
        .tec_o(tec), .rec_o(rec)
    );

    can_irq_flags #(.N(NSRC)) u_flags (
        .clk(clk), .rst(rst),
        .evt_i(evt_i), .clr_i(clr), .en_i(en),
        .flag_o(flags), .irq_o(irq_o)
    );

    assign berr_in = '{kind: berr_kind_i, rx_dir: berr_rx_i, seg: berr_seg_i};

    can_err_capture #(.PW(POS_W)) u_cap (
        .clk(clk), .rst(rst),
        .berr_evt_i(evt_i[SRC_BERR]),
        .berr_held_i(flags[SRC_BERR] && !clr[SRC_BERR]),
        .berr_i(berr_in),
        .arb_evt_i(evt_i[SRC_ARB]),
        .arb_held_i(flags[SRC_ARB] && !clr[SRC_ARB]),
        .arb_pos_i(arb_pos_i),
        .berr_o(berr_cap), .arb_o(arb_cap)
    );

    assign mode_o = mode;

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            ADR_MODE: reg_rdata = {{(DATA_W-5){1'b0}}, mode};
            ADR_STAT: reg_rdata = pack_status(berr_cap, arb_cap, lvl, ovr, rx_rdy);
            ADR_FLAG: reg_rdata = {{(DATA_W-NSRC){1'b0}}, flags};
            ADR_EN:   reg_rdata = {{(DATA_W-NSRC){1'b0}}, en};
            ADR_ECNT: reg_rdata = {8'h00, rec, 8'h00, tec};
            default:  reg_rdata = '0;
        endcase
    end

    // R6
    cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(ADR_CMD)) |-> (reg_rdata == '0));
    // R7
    rx_rdy_follow_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i[SRC_RX] |=> reg_rdata_rx_rdy_dummy_ok);
    logic reg_rdata_rx_rdy_dummy_ok;
    assign reg_rdata_rx_rdy_dummy_ok = rx_rdy;
endmodule

// File: tb/can_irq_status_core_tb.sv
`timescale 1ns/1ps
module can_irq_status_core_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [7:0]  evt_i;
    logic [1:0]  berr_kind_i;
    logic        berr_rx_i;
    logic [4:0]  berr_seg_i, arb_pos_i;
    logic [5:0]  eng_lvl_i;
    logic        ecnt_upd_i;
    logic [7:0]  ecnt_tx_i, ecnt_rx_i;
    logic [4:0]  mode_o;
    logic [5:0]  cmd_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    can_irq_status_core u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .berr_kind_i(berr_kind_i), .berr_rx_i(berr_rx_i), .berr_seg_i(berr_seg_i),
        .arb_pos_i(arb_pos_i), .eng_lvl_i(eng_lvl_i), .ecnt_upd_i(ecnt_upd_i),
        .ecnt_tx_i(ecnt_tx_i), .ecnt_rx_i(ecnt_rx_i), .mode_o(mode_o),
        .cmd_o(cmd_o), .irq_o(irq_o)
    );

    localparam logic [2:0] A_MODE = 3'd0, A_CMD = 3'd1, A_STAT = 3'd2,
                           A_FLAG = 3'd3, A_EN = 3'd4, A_ECNT = 3'd5;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [7:0] m);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; evt_i = '0;
        berr_kind_i = '0; berr_rx_i = 1'b0; berr_seg_i = '0; arb_pos_i = '0;
        eng_lvl_i = 6'b00_1111; ecnt_upd_i = 1'b0; ecnt_tx_i = '0; ecnt_rx_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(A_MODE, v); chk("R1 mode", v, 32'h1);
        rd(A_STAT, v); chk("R1 status", v, 32'h3C);
        rd(A_FLAG, v); chk("R1 flags", v, 32'h0);
        rd(A_EN, v);   chk("R1 enables", v, 32'h0);
        rd(A_ECNT, v); chk("R1 errcnt", v, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2 / R4 / R3: each source alone
        for (int i = 0; i < 8; i++) begin
            pulse(8'(1 << i));
            rd(A_FLAG, v); chk("R2 flag position", v, 32'(1 << i));
            chk("R4 irq disabled", {31'b0, irq_o}, 32'h0);
            wr(A_EN, 32'(1 << i));
            chk("R4 irq enabled", {31'b0, irq_o}, 32'h1);
            wr(A_FLAG, 32'(1 << i));
            rd(A_FLAG, v); chk("R3 single clear", v, 32'h0);
            chk("R4 irq after clear", {31'b0, irq_o}, 32'h0);
            wr(A_EN, 32'h0);
        end

        // R3 sweep of clear masks
        for (int m = 0; m < 256; m++) begin
            pulse(8'hFF);
            wr(A_FLAG, 32'(m));
            rd(A_FLAG, v); chk("R3 w1c mask", v, 32'((~m) & 8'hFF));
        end
        wr(A_FLAG, 32'hFF);

        // R4 sweep of enable masks over fixed flags
        pulse(8'hA5);
        for (int e = 0; e < 256; e++) begin
            wr(A_EN, 32'(e));
            chk("R4 irq gating", {31'b0, irq_o}, {31'b0, ((e & 8'hA5) != 0)});
        end
        wr(A_EN, 32'h0);
        wr(A_FLAG, 32'hFF);

        // R3 same-cycle event and clear
        pulse(8'h20);
        reg_we = 1'b1; reg_addr = A_FLAG; reg_wdata = 32'h20; evt_i = 8'h20;
        @(negedge clk);
        reg_we = 1'b0; evt_i = '0;
        rd(A_FLAG, v); chk("R3 event beats clear", v, 32'h20);
        wr(A_FLAG, 32'hFF);

        // R5 mode register
        wr(A_MODE, 32'h1F); chk("R5 all bits in reset mode", {27'b0, mode_o}, 32'h1F);
        wr(A_MODE, 32'h06); rd(A_MODE, v); chk("R5 leave reset mode", v, 32'h06);
        wr(A_MODE, 32'h18); chk("R5 guarded bits ignored", {27'b0, mode_o}, 32'h00);
        wr(A_MODE, 32'h19); chk("R5 guard uses prior reset bit", {27'b0, mode_o}, 32'h01);
        wr(A_MODE, 32'h19); chk("R5 guarded bits accepted", {27'b0, mode_o}, 32'h19);

        // R6 command pulses
        for (int b = 0; b < 6; b++) begin
            wr(A_CMD, 32'(1 << b));
            chk("R6 cmd pulse", {26'b0, cmd_o}, 32'(1 << b));
            rd(A_CMD, v); chk("R6 cmd reads zero", v, 32'h0);
            @(negedge clk);
            chk("R6 cmd one cycle", {26'b0, cmd_o}, 32'h0);
        end

        // R7 receive ready and overrun status bits
        pulse(8'h01);
        rd(A_STAT, v); chk("R7 rx ready set", {31'b0, v[0]}, 32'h1);
        wr(A_CMD, 32'h04);
        rd(A_STAT, v); chk("R7 rx ready released", {31'b0, v[0]}, 32'h0);
        pulse(8'h08);
        rd(A_STAT, v); chk("R7 overrun set", {31'b0, v[1]}, 32'h1);
        wr(A_FLAG, 32'h08);
        rd(A_STAT, v); chk("R7 overrun kept by flag write", {31'b0, v[1]}, 32'h1);
        reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = 32'h08; evt_i = 8'h08;
        @(negedge clk);
        reg_we = 1'b0; evt_i = '0;
        rd(A_STAT, v); chk("R7 overrun set beats clear", {31'b0, v[1]}, 32'h1);
        wr(A_CMD, 32'h08);
        rd(A_STAT, v); chk("R7 overrun cleared by command", {31'b0, v[1]}, 32'h0);
        wr(A_FLAG, 32'hFF);

        // R8 level status sweep
        for (int l = 0; l < 64; l++) begin
            eng_lvl_i = 6'(l);
            @(negedge clk);
            rd(A_STAT, v); chk("R8 level bits", {26'b0, v[7:2]}, 32'(l));
        end
        eng_lvl_i = 6'b00_1111;

        // R9 bus error capture, all codes, with freeze
        for (int c = 0; c < 256; c++) begin
            wr(A_FLAG, 32'h80);
            {berr_kind_i, berr_rx_i, berr_seg_i} = 8'(c);
            pulse(8'h80);
            rd(A_STAT, v); chk("R9 bus error capture", {24'b0, v[23:16]}, 32'(c));
            {berr_kind_i, berr_rx_i, berr_seg_i} = 8'(~c);
            pulse(8'h80);
            rd(A_STAT, v); chk("R9 bus error frozen", {24'b0, v[23:16]}, 32'(c));
        end
        wr(A_FLAG, 32'hFF);

        // R10 arbitration position capture with freeze
        for (int p = 0; p < 32; p++) begin
            wr(A_FLAG, 32'h40);
            arb_pos_i = 5'(p);
            pulse(8'h40);
            rd(A_STAT, v); chk("R10 arb capture", {27'b0, v[12:8]}, 32'(p));
            arb_pos_i = 5'(~p);
            pulse(8'h40);
            rd(A_STAT, v); chk("R10 arb frozen", {27'b0, v[12:8]}, 32'(p));
        end
        wr(A_FLAG, 32'hFF);

        // R11 error counters
        ecnt_upd_i = 1'b1; ecnt_tx_i = 8'h12; ecnt_rx_i = 8'h34;
        @(negedge clk);
        ecnt_upd_i = 1'b0;
        rd(A_ECNT, v); chk("R11 engine update", v, 32'h0034_0012);
        wr(A_ECNT, 32'h0);
        rd(A_ECNT, v); chk("R11 write zero clears", v, 32'h0);
        wr(A_ECNT, 32'hFFAB_FFCD);
        rd(A_ECNT, v); chk("R11 host load fields", v, 32'h00AB_00CD);
        ecnt_upd_i = 1'b1; ecnt_tx_i = 8'h55; ecnt_rx_i = 8'h66;
        wr(A_ECNT, 32'h0011_0022);
        ecnt_upd_i = 1'b0;
        rd(A_ECNT, v); chk("R11 host wins", v, 32'h0011_0022);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule